// File: doc/BRIEF.md
# I2S Transmitter with Selectable Clock and Word-Select Routing

This block serialises stereo PCM sample pairs onto an I2S data line. The bit clock and the word-select (WS) source are not fixed: a role bit and a four-bit routing code choose them. In the master role the bit clock can come from a local rate-divider output or from the receive side's reference clock, with WS built inside the block. It can also borrow both the receive bit clock and the receive WS, which gives a shared four-wire link. In the slave role the bit clock and WS come from dedicated external inputs, or from the receive side. One master routing code also drives a master-clock output.

Every candidate clock and WS input is captured in the system clock domain, and bit-clock edges are found there. All state therefore runs on one clock. A sample pair is taken through a valid/ready handshake at the start of each frame. If no pair is offered at that point, the previous pair is sent again and a one-cycle underrun pulse is raised.

Top module: `i2s_tx_cfgclk`

## Requirements
- R1: Master role (`tx_slave`=0), code 0000: `bclk_out` follows `div_clk` one system clock later, WS is generated internally, and `mclk_out` stays 0.
- R2: Master role, code 0010: `bclk_out` follows `rx_ref_clk` one system clock later, and WS is generated internally.
- R3: Master role, code 0100: `bclk_out` follows `rx_bclk` and `ws_out` follows `rx_ws`, each one system clock later.
- R4: Master role, code 1000: behaves as R1, except that `mclk_out` equals `div_clk`.
- R5: Slave role (`tx_slave`=1), code 0000: `bclk_out` follows `ext_bclk` and `ws_out` follows `ext_ws`, one system clock later.
- R6: Slave role, code 0010: `bclk_out` follows `rx_ref_clk` and `ws_out` follows `ext_ws`, one system clock later.
- R7: Slave role, code 0100: `bclk_out` follows `rx_bclk` and `ws_out` follows `rx_ws`, one system clock later.
- R8: Any other code falls back to code 0000 of the selected role. `mclk_out` is 0 unless the role is master and the code is 1000.
- R9: An internally generated WS holds for DATA_W bit clocks, then toggles. WS=0 carries the left word and WS=1 the right word.
- R10: `sd_out` changes only in the system clock after a detected bit-clock fall. Each word goes out MSB first, starting one bit clock after its WS change.
- R11: `sample_ready` is high for one cycle at each left-word start. When `sample_valid` is also high, `left_data` goes out in that frame's left slot, MSB appearing on the next cycle, and `right_data` goes out in its right slot.
- R12: A frame start without `sample_valid` resends the previous pair. `underrun` is then high for exactly the one following system clock.
- R13: While `rst_n` is low, `sd_out`, `ws_out`, `bclk_out`, `sample_ready` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_slave | input | 1 | Role: 0 master, 1 slave |
| tx_mode | input | 4 | Clock/WS routing code |
| div_clk | input | 1 | Local rate-divider output |
| rx_ref_clk | input | 1 | Receive-side reference clock |
| rx_bclk | input | 1 | Receive-side bit clock |
| rx_ws | input | 1 | Receive-side WS |
| ext_bclk | input | 1 | External transmit bit clock |
| ext_ws | input | 1 | External transmit WS |
| left_data | input | DATA_W | Left sample |
| right_data | input | DATA_W | Right sample |
| sample_valid | input | 1 | Sample pair offered |
| sample_ready | output | 1 | Sample pair taken this cycle |
| sd_out | output | 1 | Serial data |
| bclk_out | output | 1 | Selected bit clock |
| ws_out | output | 1 | Selected WS |
| mclk_out | output | 1 | Master-clock output |
| underrun | output | 1 | One-cycle missed-sample pulse |

## Verification
The bench keeps the default DATA_W of 16, so each WS level lasts 16 bit clocks. A built-in receiver then rebuilds whole 16-bit words from the serial line. Each candidate clock is given its own half-period (4, 3, 5 and 6 system clocks). Comparing `bclk_out` and `ws_out` cycle by cycle against each candidate shows which source every routing code picked. Each code that falls back has its own vector.

// File: rtl/i2s_txc_pkg.sv
package i2s_txc_pkg;

  typedef enum logic [1:0] {
    BSRC_DIV    = 2'd0,
    BSRC_RXREF  = 2'd1,
    BSRC_RXBCLK = 2'd2,
    BSRC_EXT    = 2'd3
  } bsrc_e;

  typedef enum logic [1:0] {
    WSRC_INT = 2'd0,
    WSRC_RX  = 2'd1,
    WSRC_EXT = 2'd2
  } wsrc_e;

  typedef struct packed {
    bsrc_e bsrc;
    wsrc_e wsrc;
    logic  mclk_en;
  } route_t;

  localparam logic [3:0] CODE_BASE = 4'b0000;
  localparam logic [3:0] CODE_REF  = 4'b0010;
  localparam logic [3:0] CODE_4W   = 4'b0100;
  localparam logic [3:0] CODE_MCLK = 4'b1000;

  function automatic route_t decode_route(input logic slave, input logic [3:0] code);
    route_t r;
    r.mclk_en = 1'b0;
    if (!slave) begin
      r.bsrc = BSRC_DIV;
      r.wsrc = WSRC_INT;
      case (code)
        CODE_REF:  r.bsrc = BSRC_RXREF;
        CODE_4W: begin
          r.bsrc = BSRC_RXBCLK;
          r.wsrc = WSRC_RX;
        end
        CODE_MCLK: r.mclk_en = 1'b1;
        default: ;
      endcase
    end else begin
      r.bsrc = BSRC_EXT;
      r.wsrc = WSRC_EXT;
      case (code)
        CODE_REF: r.bsrc = BSRC_RXREF;
        CODE_4W: begin
          r.bsrc = BSRC_RXBCLK;
          r.wsrc = WSRC_RX;
        end
        default: ;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/i2s_txc_route.sv
module i2s_txc_route
  import i2s_txc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slave,
  input  logic [3:0] code,
  input  logic       div_clk,
  input  logic       rx_ref_clk,
  input  logic       rx_bclk,
  input  logic       rx_ws,
  input  logic       ext_bclk,
  input  logic       ext_ws,
  output logic       bclk_lvl,
  output logic       bit_fall,
  output logic       ws_pin_now,
  output logic       ws_pin_prev,
  output logic       ws_internal,
  output logic       mclk_en
);

  route_t rt;
  logic   sel_bclk, sel_ws;
  logic   bclk_q, bclk_q2, ws_q, ws_q2;
  logic   bclk_d, bclk2_d, ws_d, ws2_d;

  assign rt = decode_route(slave, code);

  always_comb begin
    case (rt.bsrc)
      BSRC_RXREF:  sel_bclk = rx_ref_clk;
      BSRC_RXBCLK: sel_bclk = rx_bclk;
      BSRC_EXT:    sel_bclk = ext_bclk;
      default:     sel_bclk = div_clk;
    endcase
    sel_ws = (rt.wsrc == WSRC_RX) ? rx_ws : ext_ws;
  end

  // next-state: capture the selected sources and keep one cycle of history
  always_comb begin
    bclk_d  = sel_bclk;
    bclk2_d = bclk_q;
    ws_d    = sel_ws;
    ws2_d   = ws_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_q2 <= 1'b0;
      ws_q    <= 1'b0;
      ws_q2   <= 1'b0;
    end else begin
      bclk_q  <= bclk_d;
      bclk_q2 <= bclk2_d;
      ws_q    <= ws_d;
      ws_q2   <= ws2_d;
    end
  end

  assign bclk_lvl    = bclk_q;
  assign bit_fall    = bclk_q2 & ~bclk_q;
  assign ws_pin_now  = ws_q;
  assign ws_pin_prev = ws_q2;
  assign ws_internal = (rt.wsrc == WSRC_INT);
  assign mclk_en     = rt.mclk_en;

endmodule

// File: rtl/i2s_txc_wsgen.sv
module i2s_txc_wsgen #(
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_fall,
  output logic ws_int
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ws_q, ws_d;

  always_comb begin
    cnt_d = cnt_q;
    ws_d  = ws_q;
    if (bit_fall) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        ws_d  = ~ws_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ws_q  <= 1'b0;
    end else if (bit_fall) begin
      cnt_q <= cnt_d;
      ws_q  <= ws_d;
    end
  end

  assign ws_int = ws_q;

  AST_WS_HOLDS_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(ws_int)); // R9

endmodule

// File: rtl/i2s_txc_shifter.sv
module i2s_txc_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_fall,
  input  logic              ws_level,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  input  logic              sample_valid,
  output logic              sample_ready,
  output logic              sd_out,
  output logic              underrun
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] lhold_q, lhold_d, rhold_q, rhold_d;
  logic              ws_last_q, ws_last_d;
  logic              urun_q, urun_d;
  logic              word_start, frame_start;

  assign word_start  = bit_fall & (ws_level != ws_last_q);
  assign frame_start = word_start & ~ws_level;

  always_comb begin
    sh_d      = sh_q;
    lhold_d   = lhold_q;
    rhold_d   = rhold_q;
    ws_last_d = ws_last_q;
    urun_d    = frame_start & ~sample_valid;
    if (bit_fall) begin
      ws_last_d = ws_level;
      if (word_start) begin
        if (ws_level) begin
          sh_d = rhold_q;
        end else if (sample_valid) begin
          sh_d    = left_in;
          lhold_d = left_in;
          rhold_d = right_in;
        end else begin
          sh_d = lhold_q;
        end
      end else begin
        sh_d = {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      lhold_q   <= '0;
      rhold_q   <= '0;
      ws_last_q <= 1'b0;
      urun_q    <= 1'b0;
    end else begin
      urun_q <= urun_d;
      if (bit_fall) begin
        sh_q      <= sh_d;
        lhold_q   <= lhold_d;
        rhold_q   <= rhold_d;
        ws_last_q <= ws_last_d;
      end
    end
  end

  assign sample_ready = frame_start;
  assign sd_out       = sh_q[DATA_W-1];
  assign underrun     = urun_q;

  AST_SD_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(sd_out)); // R10
  AST_LEFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ready && sample_valid) |=> (sd_out == $past(left_in[DATA_W-1]))); // R11
  AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R12

endmodule

// File: rtl/i2s_tx_cfgclk.sv
module i2s_tx_cfgclk #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_slave,
  input  logic [3:0]        tx_mode,
  input  logic              div_clk,
  input  logic              rx_ref_clk,
  input  logic              rx_bclk,
  input  logic              rx_ws,
  input  logic              ext_bclk,
  input  logic              ext_ws,
  input  logic [DATA_W-1:0] left_data,
  input  logic [DATA_W-1:0] right_data,
  input  logic              sample_valid,
  output logic              sample_ready,
  output logic              sd_out,
  output logic              bclk_out,
  output logic              ws_out,
  output logic              mclk_out,
  output logic              underrun
);

  logic [1:0] rst_pipe_q;
  logic       core_rst_n;
  logic       bclk_lvl, bit_fall, ws_pin_now, ws_pin_prev, ws_internal, mclk_en;
  logic       ws_int, ws_level;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  i2s_txc_route u_route (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .slave       (tx_slave),
    .code        (tx_mode),
    .div_clk     (div_clk),
    .rx_ref_clk  (rx_ref_clk),
    .rx_bclk     (rx_bclk),
    .rx_ws       (rx_ws),
    .ext_bclk    (ext_bclk),
    .ext_ws      (ext_ws),
    .bclk_lvl    (bclk_lvl),
    .bit_fall    (bit_fall),
    .ws_pin_now  (ws_pin_now),
    .ws_pin_prev (ws_pin_prev),
    .ws_internal (ws_internal),
    .mclk_en     (mclk_en)
  );

  i2s_txc_wsgen #(.DATA_W(DATA_W)) u_wsgen (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .bit_fall (bit_fall),
    .ws_int   (ws_int)
  );

  // WS level of the bit period that ends at this fall
  assign ws_level = ws_internal ? ws_int : ws_pin_prev;

  i2s_txc_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .bit_fall     (bit_fall),
    .ws_level     (ws_level),
    .left_in      (left_data),
    .right_in     (right_data),
    .sample_valid (sample_valid),
    .sample_ready (sample_ready),
    .sd_out       (sd_out),
    .underrun     (underrun)
  );

  assign bclk_out = bclk_lvl;
  assign ws_out   = ws_internal ? ws_int : ws_pin_now;
  assign mclk_out = mclk_en & div_clk;

  AST_MCLK_HELD_LOW: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(!tx_slave && tx_mode == 4'b1000) |-> !mclk_out); // R8

endmodule

// File: tb/i2s_tx_cfgclk_test.sv
module i2s_tx_cfgclk_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NV = 9;
  localparam int WD_CYCLES = 150000;

  // {slave, code[3:0], bclk src (0 div,1 ref,2 rx,3 ext), ws src (0 int,1 rx,2 ext), mclk, left, right}
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 4'b0000, 2'd0, 2'd0, 1'b0, 16'hA5C3, 16'h3C5A},
    {1'b0, 4'b0010, 2'd1, 2'd0, 1'b0, 16'h8001, 16'h7FFE},
    {1'b0, 4'b0100, 2'd2, 2'd1, 1'b0, 16'hC001, 16'h0FF0},
    {1'b0, 4'b1000, 2'd0, 2'd0, 1'b1, 16'hFFFF, 16'h0001},
    {1'b1, 4'b0000, 2'd3, 2'd2, 1'b0, 16'h9234, 16'h1357},
    {1'b1, 4'b0010, 2'd1, 2'd2, 1'b0, 16'hB00B, 16'h600D},
    {1'b1, 4'b0100, 2'd2, 2'd1, 1'b0, 16'h8421, 16'hF0F0},
    {1'b0, 4'b0110, 2'd0, 2'd0, 1'b0, 16'hDEAD, 16'hBEEF},
    {1'b1, 4'b1000, 2'd3, 2'd2, 1'b0, 16'hCAFE, 16'h0A0A}
  };

  logic clk = 1'b0;
  logic rst_n, tx_slave, sample_valid;
  logic [3:0] tx_mode;
  logic div_clk = 0, rx_ref_clk = 0, rx_bclk = 0, rx_ws = 0, ext_bclk = 0, ext_ws = 0;
  logic [DW-1:0] left_data, right_data;
  logic sample_ready, sd_out, bclk_out, ws_out, mclk_out, underrun;

  int checks = 0, fails = 0;
  logic [1:0] cur_bsrc = 0, cur_wsrc = 0;
  logic cur_mclk = 0, ews_on_ref = 0;
  int bmis = 0, wmis = 0, mmis = 0;
  int lc = 0, rc = 0, ws_run_last = 0, ws_run = 0;
  logic [DW-1:0] last_l = 0, last_r = 0, acc = 0;
  logic bclk_prev = 0, wsr_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_tx_cfgclk #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .tx_slave(tx_slave), .tx_mode(tx_mode),
    .div_clk(div_clk), .rx_ref_clk(rx_ref_clk), .rx_bclk(rx_bclk), .rx_ws(rx_ws),
    .ext_bclk(ext_bclk), .ext_ws(ext_ws), .left_data(left_data), .right_data(right_data),
    .sample_valid(sample_valid), .sample_ready(sample_ready), .sd_out(sd_out),
    .bclk_out(bclk_out), .ws_out(ws_out), .mclk_out(mclk_out), .underrun(underrun)
  );

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // receiver model, source comparison, then clock source generation
  initial begin
    int cd = 0, cr = 0, cx = 0, ce = 0, fx = 0, fe = 0, fr = 0;
    logic eb, ew;
    forever begin
      @(negedge clk);
      case (cur_bsrc)
        2'd0: eb = div_clk;
        2'd1: eb = rx_ref_clk;
        2'd2: eb = rx_bclk;
        default: eb = ext_bclk;
      endcase
      ew = (cur_wsrc == 2'd1) ? rx_ws : ext_ws;
      if (bclk_out !== eb) bmis++;
      if (cur_wsrc != 2'd0 && ws_out !== ew) wmis++;
      if (mclk_out !== (cur_mclk & div_clk)) mmis++;
      if (bclk_out && !bclk_prev) begin
        if (ws_out != wsr_prev) begin
          if (!wsr_prev) begin last_l = {acc[DW-2:0], sd_out}; lc++; end
          else           begin last_r = {acc[DW-2:0], sd_out}; rc++; end
          acc = '0;
          ws_run_last = ws_run;
          ws_run = 1;
        end else begin
          acc = {acc[DW-2:0], sd_out};
          ws_run++;
        end
        wsr_prev = ws_out;
      end
      bclk_prev = bclk_out;
      cd++; if (cd == 4) begin cd = 0; div_clk = ~div_clk; end
      cr++;
      if (cr == 3) begin
        cr = 0;
        rx_ref_clk = ~rx_ref_clk;
        if (!rx_ref_clk && ews_on_ref) begin
          fr++; if (fr == 16) begin fr = 0; ext_ws = ~ext_ws; end
        end
      end
      cx++;
      if (cx == 5) begin
        cx = 0;
        rx_bclk = ~rx_bclk;
        if (!rx_bclk) begin fx++; if (fx == 16) begin fx = 0; rx_ws = ~rx_ws; end end
      end
      ce++;
      if (ce == 6) begin
        ce = 0;
        ext_bclk = ~ext_bclk;
        if (!ext_bclk && !ews_on_ref) begin
          fe++; if (fe == 16) begin fe = 0; ext_ws = ~ext_ws; end
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(negedge clk);
    fails++;
    $display("FAIL R13 watchdog: cycles=%0d expected below %0d", WD_CYCLES, WD_CYCLES);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic wait_ready();
    for (int k = 0; k < 4000 && !sample_ready; k++) @(negedge clk);
  endtask

  task automatic wait_words();
    int l0 = lc, r0 = rc;
    for (int k = 0; k < 4000 && !(lc > l0 && rc > r0); k++) @(negedge clk);
  endtask

  task automatic run_vec(input int i);
    logic [41:0] v = VEC[i];
    string t = tag_of(i);
    @(negedge clk);
    rst_n = 1'b0;
    tx_slave = v[41]; tx_mode = v[40:37];
    cur_bsrc = v[36:35]; cur_wsrc = v[34:33]; cur_mclk = v[32];
    ews_on_ref = v[41] && (v[40:37] == 4'b0010);
    left_data = v[31:16]; right_data = v[15:0]; sample_valid = 1'b1;
    repeat (4) @(negedge clk);
    if (i == 0)
      chk({sd_out, ws_out, bclk_out, sample_ready, underrun} == 5'b0, "R13", "outputs in reset",
          {sd_out, ws_out, bclk_out, sample_ready, underrun}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bmis = 0; wmis = 0; mmis = 0;
    wait_ready();
    chk(sample_ready, "R11", "ready at frame start", sample_ready, 1);
    @(negedge clk);
    chk(sd_out == v[31], "R10", "left MSB first", sd_out, v[31]);
    wait_words();
    chk(last_l == v[31:16], "R11", "left word", last_l, v[31:16]);
    chk(last_r == v[15:0], "R11", "right word", last_r, v[15:0]);
    chk(ws_run_last == DW, "R9", "WS run in bit clocks", ws_run_last, DW);
    chk(bmis == 0, t, "bit clock source mismatches", bmis, 0);
    if (v[34:33] != 2'd0) chk(wmis == 0, t, "WS source mismatches", wmis, 0);
    chk(mmis == 0, v[32] ? "R4" : "R8", "mclk mismatches", mmis, 0);
  endtask

  initial begin
    rst_n = 1'b0; tx_slave = 0; tx_mode = 0; sample_valid = 0;
    left_data = 0; right_data = 0;
    for (int i = 0; i < NV; i++) run_vec(i);

    // underrun: drop valid after pair A is flowing
    run_vec(0);
    sample_valid = 1'b0;
    wait_ready();
    chk(underrun == 1'b0, "R12", "no flag before miss", underrun, 0);
    @(negedge clk);
    chk(underrun == 1'b1, "R12", "flag after missed frame", underrun, 1);
    @(negedge clk);
    chk(underrun == 1'b0, "R12", "flag lasts one cycle", underrun, 0);
    wait_words();
    chk(last_l == VEC[0][31:16], "R12", "left resent", last_l, VEC[0][31:16]);
    chk(last_r == VEC[0][15:0], "R12", "right resent", last_r, VEC[0][15:0]);
    left_data = 16'h1234; right_data = 16'h4321; sample_valid = 1'b1;
    wait_ready();
    @(negedge clk);
    chk(underrun == 1'b0, "R12", "no flag with valid", underrun, 0);
    wait_words();
    chk(last_l == 16'h1234, "R11", "left after recovery", last_l, 16'h1234);
    chk(last_r == 16'h4321, "R11", "right after recovery", last_r, 16'h4321);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule